// File: doc/BRIEF.md
# DMA Source Transaction Selector

This block is the source-side request logic of one DMA channel when the channel itself decides how long a block is. Software or the channel sequencer hands it a block length in bytes, a beat-width code and a burst-length code with a one-cycle start strobe. The block keeps a count of the bytes still owed by the source. It watches the source peripheral's burst-request and single-request lines, and for each transfer it tells a bus-master stub to start either a burst of the decoded beat count or a single beat.

While at least one full burst of bytes remains, the block answers only burst requests. Once the remainder drops below one burst, the channel is in the single-transaction region and answers only single requests. When the count reaches zero, the block raises a finish signal toward the source. That signal stays high until the peripheral has released both request lines, which closes a four-phase handshake. A zero-length block skips straight to that handshake.

Top module: `dma_src_txn_sel`

## Requirements
- R1: Width code 000 gives 1-byte beats, 001 gives 2-byte beats and 010 gives 4-byte beats. Larger codes are treated as 010. Each single transaction takes one beat's worth of bytes off the remaining count.
- R2: Burst code 000 gives 1 beat, 001 gives 4, 010 gives 8 and 011 gives 16. Larger codes are treated as 011. A burst takes beats times beat width bytes off the remaining count.
- R3: While the remaining count is at least one burst, a burst request sampled high on a clock edge produces `txn_start_o` high in the next cycle, with `txn_single_o` low and `txn_beats_o` equal to the decoded burst length.
- R4: `single_rgn_o` is high while a block is waiting for a request and fewer bytes than one burst remain. It is low while a full burst remains.
- R5: In the single-transaction region, a single request sampled high produces `txn_start_o` high in the next cycle, with `txn_single_o` high and `txn_beats_o` equal to 1.
- R6: Single requests are ignored while a full burst remains. Burst requests are ignored in the single-transaction region.
- R7: Only one transaction is outstanding at a time, so `txn_start_o` is never high on two consecutive cycles. After `txn_done_i` for the transaction that empties the count, `finish_o` is high in the next cycle.
- R8: `finish_o` stays high while either request line is high, and no transaction starts during that time. It falls in the cycle after both request lines are sampled low.
- R9: A start strobe with a block length of zero starts no transaction and drives `finish_o` high in the next cycle.
- R10: After reset, `txn_start_o`, `finish_o` and `single_rgn_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| blk_start_i | input | 1 | One-cycle strobe that loads a new block while the block is idle |
| blk_bytes_i | input | BYTES_W | Block length in bytes |
| width_code_i | input | 3 | Beat-width code |
| burst_code_i | input | 3 | Burst-length code |
| breq_i | input | 1 | Burst request from the source peripheral |
| sreq_i | input | 1 | Single request from the source peripheral |
| txn_done_i | input | 1 | Bus-master stub reports that the current transaction is complete |
| txn_start_o | output | 1 | One-cycle command to start a transaction |
| txn_single_o | output | 1 | Marks the started transaction as a single beat |
| txn_beats_o | output | MAX_B_CODE+2 | Beat count of the started transaction |
| finish_o | output | 1 | Block-complete handshake toward the source peripheral |
| single_rgn_o | output | 1 | Channel is in the single-transaction region |

## Verification
Each transaction start is due exactly one cycle after the edge that samples the request. `finish_o` is due one cycle after the edge that takes the final `txn_done_i`, or one cycle after a zero-length start strobe, and it drops one cycle after both requests are seen low. The bench changes inputs only on falling edges and reads outputs on the next falling edge, which lands in the cycle each result is due. It also holds the wrong kind of request for several cycles before each transaction and confirms that no start appears. The configuration sweep covers every width and burst code with block lengths chosen around the burst boundary, and the bench derives the expected burst and single sequence arithmetically for each one.

// File: rtl/dma_src_pkg.sv
package dma_src_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACT  = 2'd1,
    ST_BUSY = 2'd2,
    ST_FIN  = 2'd3
  } src_st_e;

endpackage

// File: rtl/dma_src_size_dec.sv
module dma_src_size_dec #(
  parameter int BYTES_W    = 16,
  parameter int MAX_W_CODE = 2,
  parameter int MAX_B_CODE = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [2:0]              width_code_i,
  input  logic [2:0]              burst_code_i,
  output logic [BYTES_W-1:0]      beat_bytes_o,
  output logic [MAX_B_CODE+1:0]   burst_beats_o,
  output logic [BYTES_W-1:0]      burst_bytes_o
);
  localparam int          BEATS_W = MAX_B_CODE + 2;
  localparam logic [2:0]  W_MAX   = 3'(MAX_W_CODE);
  localparam logic [2:0]  B_MAX   = 3'(MAX_B_CODE);

  logic [2:0] wc_q, bc_q;

  // codes are held for the whole block
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wc_q <= '0;
      bc_q <= '0;
    end else if (load_i) begin
      wc_q <= (width_code_i > W_MAX) ? W_MAX : width_code_i;
      bc_q <= (burst_code_i > B_MAX) ? B_MAX : burst_code_i;
    end
  end

  always_comb begin
    beat_bytes_o  = BYTES_W'(1) << wc_q;
    burst_beats_o = (bc_q == 3'd0) ? BEATS_W'(1) : (BEATS_W'(1) << (bc_q + 3'd1));
    burst_bytes_o = BYTES_W'(burst_beats_o) << wc_q;
  end

endmodule

// File: rtl/dma_src_rem_cnt.sv
module dma_src_rem_cnt #(
  parameter int BYTES_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [BYTES_W-1:0] load_val_i,
  input  logic               dec_i,
  input  logic [BYTES_W-1:0] dec_amt_i,
  input  logic [BYTES_W-1:0] burst_bytes_i,
  output logic               zero_o,
  output logic               below_burst_o
);
  logic [BYTES_W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= load_val_i;
    end else if (dec_i) begin
      // saturate on a ragged tail
      rem_q <= (rem_q > dec_amt_i) ? rem_q - dec_amt_i : '0;
    end
  end

  assign zero_o        = (rem_q == '0);
  assign below_burst_o = (rem_q < burst_bytes_i);

endmodule

// File: rtl/dma_src_ctrl.sv
module dma_src_ctrl
  import dma_src_pkg::*;
#(
  parameter int BEATS_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               blk_start_i,
  input  logic               blk_zero_i,
  input  logic               breq_i,
  input  logic               sreq_i,
  input  logic               txn_done_i,
  input  logic               rem_zero_i,
  input  logic               below_burst_i,
  input  logic [BEATS_W-1:0] burst_beats_i,
  output logic               load_o,
  output logic               dec_o,
  output logic               dec_single_o,
  output logic               txn_start_o,
  output logic               txn_single_o,
  output logic [BEATS_W-1:0] txn_beats_o,
  output logic               finish_o,
  output logic               single_rgn_o
);
  src_st_e            st_q, st_d;
  logic               go_burst, go_single;
  logic               start_q, single_q;
  logic [BEATS_W-1:0] beats_q;

  always_comb begin
    st_d      = st_q;
    go_burst  = 1'b0;
    go_single = 1'b0;
    load_o    = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (blk_start_i) begin
          load_o = 1'b1;
          st_d   = blk_zero_i ? ST_FIN : ST_ACT;
        end
      end
      ST_ACT: begin
        if (below_burst_i) begin
          if (sreq_i) begin
            go_single = 1'b1;
            st_d      = ST_BUSY;
          end
        end else if (breq_i) begin
          go_burst = 1'b1;
          st_d     = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (txn_done_i) st_d = rem_zero_i ? ST_FIN : ST_ACT;
      end
      ST_FIN: begin
        // four-phase close: wait for both request lines to drop
        if (!breq_i && !sreq_i) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign dec_o        = go_burst | go_single;
  assign dec_single_o = go_single;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      start_q  <= 1'b0;
      single_q <= 1'b0;
      beats_q  <= '0;
    end else begin
      st_q    <= st_d;
      start_q <= dec_o;
      if (dec_o) begin
        single_q <= go_single;
        beats_q  <= go_single ? BEATS_W'(1) : burst_beats_i;
      end
    end
  end

  assign txn_start_o  = start_q;
  assign txn_single_o = single_q;
  assign txn_beats_o  = beats_q;
  assign finish_o     = (st_q == ST_FIN);
  assign single_rgn_o = ((st_q == ST_ACT) || (st_q == ST_BUSY)) && below_burst_i;

endmodule

// File: rtl/dma_src_txn_sel.sv
module dma_src_txn_sel #(
  parameter int BYTES_W    = 16,
  parameter int MAX_W_CODE = 2,
  parameter int MAX_B_CODE = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  blk_start_i,
  input  logic [BYTES_W-1:0]    blk_bytes_i,
  input  logic [2:0]            width_code_i,
  input  logic [2:0]            burst_code_i,
  input  logic                  breq_i,
  input  logic                  sreq_i,
  input  logic                  txn_done_i,
  output logic                  txn_start_o,
  output logic                  txn_single_o,
  output logic [MAX_B_CODE+1:0] txn_beats_o,
  output logic                  finish_o,
  output logic                  single_rgn_o
);
  localparam int BEATS_W = MAX_B_CODE + 2;

  logic               load, dec, dec_single, rem_zero, below_burst;
  logic [BYTES_W-1:0] beat_bytes, burst_bytes, dec_amt;
  logic [BEATS_W-1:0] burst_beats;

  dma_src_size_dec #(
    .BYTES_W   (BYTES_W),
    .MAX_W_CODE(MAX_W_CODE),
    .MAX_B_CODE(MAX_B_CODE)
  ) u_size_dec (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .width_code_i (width_code_i),
    .burst_code_i (burst_code_i),
    .beat_bytes_o (beat_bytes),
    .burst_beats_o(burst_beats),
    .burst_bytes_o(burst_bytes)
  );

  assign dec_amt = dec_single ? beat_bytes : burst_bytes;

  dma_src_rem_cnt #(
    .BYTES_W(BYTES_W)
  ) u_rem_cnt (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (load),
    .load_val_i   (blk_bytes_i),
    .dec_i        (dec),
    .dec_amt_i    (dec_amt),
    .burst_bytes_i(burst_bytes),
    .zero_o       (rem_zero),
    .below_burst_o(below_burst)
  );

  dma_src_ctrl #(
    .BEATS_W(BEATS_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .blk_start_i  (blk_start_i),
    .blk_zero_i   (blk_bytes_i == '0),
    .breq_i       (breq_i),
    .sreq_i       (sreq_i),
    .txn_done_i   (txn_done_i),
    .rem_zero_i   (rem_zero),
    .below_burst_i(below_burst),
    .burst_beats_i(burst_beats),
    .load_o       (load),
    .dec_o        (dec),
    .dec_single_o (dec_single),
    .txn_start_o  (txn_start_o),
    .txn_single_o (txn_single_o),
    .txn_beats_o  (txn_beats_o),
    .finish_o     (finish_o),
    .single_rgn_o (single_rgn_o)
  );

endmodule

// File: rtl/dma_src_txn_sel_chk.sv
module dma_src_txn_sel_chk #(
  parameter int BEATS_W = 5
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               breq_i,
  input logic               sreq_i,
  input logic               txn_start_o,
  input logic               txn_single_o,
  input logic [BEATS_W-1:0] txn_beats_o,
  input logic               finish_o,
  input logic               single_rgn_o
);

  assert_burst_src_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_o && !txn_single_o) |-> ($past(breq_i) && !$past(single_rgn_o)));

  assert_single_src_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_o && txn_single_o) |-> ($past(sreq_i) && $past(single_rgn_o)));

  assert_single_one_beat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (txn_start_o && txn_single_o) |-> (txn_beats_o == BEATS_W'(1)));

  assert_start_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    txn_start_o |=> !txn_start_o);

  assert_fin_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish_o && (breq_i || sreq_i)) |=> finish_o);

  assert_fin_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(finish_o) |-> $past(!breq_i && !sreq_i));

  assert_no_start_in_fin_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |-> !txn_start_o);

endmodule

bind dma_src_txn_sel dma_src_txn_sel_chk #(
  .BEATS_W(MAX_B_CODE + 2)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .breq_i      (breq_i),
  .sreq_i      (sreq_i),
  .txn_start_o (txn_start_o),
  .txn_single_o(txn_single_o),
  .txn_beats_o (txn_beats_o),
  .finish_o    (finish_o),
  .single_rgn_o(single_rgn_o)
);

// File: tb/dma_src_txn_sel_bench.sv
`timescale 1ns/1ps
module dma_src_txn_sel_bench;
  localparam int BYTES_W = 16;
  localparam int MAXB    = 3;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              blk_start = 1'b0;
  logic [BYTES_W-1:0] blk_bytes = '0;
  logic [2:0]        wcode = '0, bcode = '0;
  logic              breq = 1'b0, sreq = 1'b0, done = 1'b0;
  logic              start_o, single_o, finish_o, rgn_o;
  logic [MAXB+1:0]   beats_o;

  int unsigned n_chk = 0;
  int unsigned n_err = 0;

  always #2.5 clk = ~clk;

  dma_src_txn_sel #(.BYTES_W(BYTES_W), .MAX_W_CODE(2), .MAX_B_CODE(MAXB)) u_dma_src_txn_sel (
    .clk_i(clk), .rst_ni(rst_ni), .blk_start_i(blk_start), .blk_bytes_i(blk_bytes),
    .width_code_i(wcode), .burst_code_i(bcode), .breq_i(breq), .sreq_i(sreq),
    .txn_done_i(done), .txn_start_o(start_o), .txn_single_o(single_o),
    .txn_beats_o(beats_o), .finish_o(finish_o), .single_rgn_o(rgn_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FIL: %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic run_block(input int wc, input int bc, input int nbytes);
    int beat  = 1 << wc;
    int nbt   = (bc == 0) ? 1 : (1 << (bc + 1));
    int burst = nbt * beat;
    int rem   = nbytes;
    @(negedge clk);
    wcode = 3'(wc); bcode = 3'(bc); blk_bytes = BYTES_W'(nbytes); blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    if (nbytes == 0) begin
      chk(finish_o == 1'b1, "R9 zero block finish", int'(finish_o), 1);
      chk(start_o == 1'b0, "R9 zero block no start", int'(start_o), 0);
      @(negedge clk);
      chk(finish_o == 1'b0, "R9 zero block finish drop", int'(finish_o), 0);
      return;
    end
    while (rem > 0) begin
      bit full = (rem >= burst);
      chk(rgn_o == !full, "R4 single region flag", int'(rgn_o), int'(!full));
      // wrong-kind request must be ignored
      breq = !full; sreq = full;
      for (int i = 0; i < 3; i++) begin
        @(negedge clk);
        chk(start_o == 1'b0, "R6 wrong request ignored", int'(start_o), 0);
      end
      breq = full; sreq = !full;
      @(negedge clk);
      if (full) begin
        chk(start_o == 1'b1, "R3 burst start", int'(start_o), 1);
        chk(single_o == 1'b0, "R3 burst kind", int'(single_o), 0);
        chk(int'(beats_o) == nbt, "R2 burst beats", int'(beats_o), nbt);
        rem -= burst;
      end else begin
        chk(start_o == 1'b1, "R5 single start", int'(start_o), 1);
        chk(single_o == 1'b1, "R5 single kind", int'(single_o), 1);
        chk(int'(beats_o) == 1, "R5 single beats", int'(beats_o), 1);
        rem -= beat;
      end
      if (rem > 0) begin breq = 1'b0; sreq = 1'b0; end
      done = 1'b1;
      @(negedge clk);
      done = 1'b0;
      chk(start_o == 1'b0, "R7 start is a pulse", int'(start_o), 0);
    end
    // finish due one cycle after final done; R1 byte accounting decides when
    chk(finish_o == 1'b1, "R7 R1 finish after last done", int'(finish_o), 1);
    breq = 1'b1; sreq = 1'b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk(finish_o == 1'b1, "R8 finish held", int'(finish_o), 1);
      chk(start_o == 1'b0, "R8 no start during finish", int'(start_o), 0);
    end
    breq = 1'b0; sreq = 1'b0;
    @(negedge clk);
    chk(finish_o == 1'b0, "R8 finish drop", int'(finish_o), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL: watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(start_o == 1'b0, "R10 reset start", int'(start_o), 0);
    chk(finish_o == 1'b0, "R10 reset finish", int'(finish_o), 0);
    chk(rgn_o == 1'b0, "R10 reset region", int'(rgn_o), 0);
    rst_ni = 1'b1;
    for (int wc = 0; wc < 3; wc++) begin
      for (int bc = 0; bc < 4; bc++) begin
        int beat  = 1 << wc;
        int burst = ((bc == 0) ? 1 : (1 << (bc + 1))) * beat;
        run_block(wc, bc, 0);
        run_block(wc, bc, beat);
        run_block(wc, bc, burst);
        run_block(wc, bc, burst + beat);
        run_block(wc, bc, (3 * beat < burst) ? 2 * burst + 3 * beat : 2 * burst);
      end
    end
    // out-of-range codes clamp to the largest (R1, R2): 4-byte beats, 16 beats
    run_block(2, 3, 64 + 12);
    @(negedge clk);
    wcode = 3'd7; bcode = 3'd7; blk_bytes = BYTES_W'(64 + 4); blk_start = 1'b1;
    @(negedge clk);
    blk_start = 1'b0;
    chk(rgn_o == 1'b0, "R2 clamped burst region", int'(rgn_o), 0);
    breq = 1'b1;
    @(negedge clk);
    chk(int'(beats_o) == 16, "R2 clamped burst beats", int'(beats_o), 16);
    breq = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(rgn_o == 1'b1, "R1 clamped width remainder", int'(rgn_o), 1);
    sreq = 1'b1;
    @(negedge clk);
    chk(start_o == 1'b1 && single_o == 1'b1, "R5 clamped single", int'(single_o), 1);
    sreq = 1'b0; done = 1'b1;
    @(negedge clk);
    done = 1'b0;
    chk(finish_o == 1'b1, "R1 clamped width finish", int'(finish_o), 1);
    @(negedge clk);
    chk(finish_o == 1'b0, "R8 finish drop", int'(finish_o), 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule